// File: doc/BRIEF.md
# Byte-Parity Checker with Error Capture Register

This block sits beside a word-organised memory of 16-bit words addressed by a 22-bit byte address. On the write side it computes one odd-parity bit per byte for the memory to store next to the data. On the read side it checks the returned data against the stored parity bits. When a check fails, it records the event and the failing address in a single control and status register (CSR).

Software reaches the CSR through a plain word-wide register port. The CSR answers at one of sixteen word addresses, picked by a static select input. The captured 22-bit address is too wide for one register, so it is read through a 7-bit window. A control bit chooses whether that window shows the middle address bits or the top address bits. A diagnostic bit inverts both generated parity bits, so software can plant a bad word and confirm the checker catches it.

The memory read check is a single-cycle strobe (`mr_valid`). The block has no ready signal and never applies back-pressure: it accepts a check in every cycle, one per cycle. Write parity is purely combinational from `mw_data`.

Top module: `pcsr_top`

## Requirements
- R1: `mw_par[b]` is the odd parity of byte b of `mw_data`: byte b plus its parity bit holds an odd number of ones. Byte 0 is bits 7:0 and byte 1 is bits 15:8.
- R2: While CSR bit 2 (wrong-parity mode) is 1, both bits of `mw_par` are inverted. A word stored this way fails the read check.
- R3: A read check fails when `mr_valid` is 1 and either byte disagrees with its bit of `mr_par`, on the low byte or on the high byte. A read whose parity matches changes nothing.
- R4: On a failing read while CSR bit 15 (error flag) is 0, the next cycle has bit 15 set and the full `mr_addr` captured.
- R5: While bit 15 is 1, later failing reads change neither the flag nor the captured address. The captured address is also protected from software writes during that time.
- R6: With CSR bit 14 at 0, CSR bits 11:5 read captured address bits 17:11.
- R7: With CSR bit 14 at 1, CSR bits 8:5 read captured address bits 21:18, and bits 11:9 read 0.
- R8: `bus_perr` is 1 in the cycle after a failing read only if CSR bit 0 was 1. The capture of R4 happens whatever bit 0 holds.
- R9: A CSR write in the same cycle as a failing read wins. Bits 15, 14, 2 and 0 take the written values. While the flag is clear, the write also loads the written field into the half of the address that the written bit 14 selects.
- R10: Active-low `rst_n` (asynchronous) and `bus_init` (synchronous, taking priority over everything else) clear the CSR and `bus_perr`.
- R11: The CSR occupies byte address octal 172100 + 2*`cfg_sel`, and `reg_addr[0]` is ignored. At any other address a write has no effect and `reg_rdata` reads 0. `reg_rdata` is also 0 when `reg_rd` is 0.
- R12: CSR bits 13, 12, 4, 3 and 1 always read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous power-up reset, active low |
| bus_init | input | 1 | Synchronous bus initialise, clears the CSR |
| cfg_sel | input | 4 | Static choice among the sixteen CSR word addresses |
| reg_addr | input | 16 | Register-port byte address |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read enable |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | CSR contents when read and addressed, else 0 |
| mw_data | input | 16 | Word being written to memory |
| mw_par | output | 2 | Parity bits to store, one per byte |
| mr_valid | input | 1 | Read-check strobe |
| mr_addr | input | 22 | Byte address of the word being read |
| mr_data | input | 16 | Word read from memory |
| mr_par | input | 2 | Parity bits read from memory |
| bus_perr | output | 1 | Parity error report, one cycle after the failing read |

## Verification
The assertions assume that `reg_wr`, `mr_valid` and `bus_init` are sampled only at rising edges, and that `cfg_sel` does not change while the block runs. The same-cycle write-and-capture properties also assume that a write and a failing read may coincide, but only one of each occurs per cycle. The stimulus changes every input on the falling edge and never changes `cfg_sel` after reset. It deliberately lines up one write with one failing read to reach the priority case.

// File: rtl/pcsr_pkg.sv
package pcsr_pkg;
  localparam int WORD_W   = 16;
  localparam int BYTE_W   = 8;
  localparam int NBYTES   = WORD_W / BYTE_W;
  localparam int FLD_W    = 7;   // width of the address window in the CSR
  localparam int WIN_LSB  = 11;  // lowest captured address bit shown with ext=0
  localparam int B_FLAG   = 15;
  localparam int B_EXT    = 14;
  localparam int B_FLD    = 5;
  localparam int B_WWP    = 2;
  localparam int B_PEN    = 0;

  typedef struct packed {
    logic flag;
    logic ext;
    logic wwp;
    logic pen;
  } ctl_t;
endpackage

// File: rtl/pcsr_par_gen.sv
module pcsr_par_gen
  import pcsr_pkg::*;
#(
  parameter int NB = NBYTES,
  parameter int BW = BYTE_W
) (
  input  logic [NB*BW-1:0] d,
  output logic [NB-1:0]    p
);
  for (genvar i = 0; i < NB; i++) begin : g_byte
    assign p[i] = ~^d[i*BW +: BW];
  end
endmodule

// File: rtl/pcsr_decode.sv
module pcsr_decode #(
  parameter int                BUS_AW = 16,
  parameter int                SEL_W  = 4,
  parameter logic [BUS_AW-1:0] BASE   = 16'o172100
) (
  input  logic [BUS_AW-1:0] addr,
  input  logic [SEL_W-1:0]  sel,
  output logic              hit
);
  localparam int LOW = SEL_W + 1;
  logic unused_lsb;
  assign unused_lsb = addr[0];
  assign hit = (addr[BUS_AW-1:LOW] == BASE[BUS_AW-1:LOW]) && (addr[LOW-1:1] == sel);
endmodule

// File: rtl/pcsr_regs.sv
module pcsr_regs
  import pcsr_pkg::*;
#(
  parameter int ADDR_W = 22
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              init,
  input  logic              sw_we,
  input  logic [WORD_W-1:0] wdata,
  input  logic              hw_err,
  input  logic [ADDR_W-1:0] err_addr,
  output ctl_t              ctl,
  output logic [ADDR_W-1:0] cap
);
  localparam int HI_LSB = WIN_LSB + FLD_W;
  localparam int HI_W   = ADDR_W - HI_LSB;

  logic unused_rsv;
  assign unused_rsv = ^{wdata[13:12], wdata[4:3], wdata[1]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl <= '0;
      cap <= '0;
    end else if (init) begin
      ctl <= '0;
      cap <= '0;
    end else if (sw_we) begin
      ctl.flag <= wdata[B_FLAG];
      ctl.ext  <= wdata[B_EXT];
      ctl.wwp  <= wdata[B_WWP];
      ctl.pen  <= wdata[B_PEN];
      if (!ctl.flag) begin
        if (wdata[B_EXT]) cap[ADDR_W-1:HI_LSB] <= wdata[B_FLD +: HI_W];
        else              cap[HI_LSB-1:WIN_LSB] <= wdata[B_FLD +: FLD_W];
      end
    end else if (hw_err && !ctl.flag) begin
      ctl.flag <= 1'b1;
      cap      <= err_addr;
    end
  end

  a_r4_first_capture: assert property (@(posedge clk) disable iff (!rst_n)
    (hw_err && !ctl.flag && !sw_we && !init) |=> (ctl.flag && cap == $past(err_addr)));
  a_r5_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl.flag && !sw_we && !init) |=> ctl.flag);
  a_r5_addr_held: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl.flag && !init) |=> $stable(cap));
  a_r9_sw_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (sw_we && !init) |=> (ctl.flag == $past(wdata[B_FLAG])));
  a_r10_init_clears: assert property (@(posedge clk) disable iff (!rst_n)
    init |=> (ctl == '0 && cap == '0));
endmodule

// File: rtl/pcsr_top.sv
module pcsr_top
  import pcsr_pkg::*;
#(
  parameter int                ADDR_W   = 22,
  parameter int                SEL_W    = 4,
  parameter int                BUS_AW   = 16,
  parameter logic [BUS_AW-1:0] CSR_BASE = 16'o172100
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_init,
  input  logic [SEL_W-1:0]  cfg_sel,
  input  logic [BUS_AW-1:0] reg_addr,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [WORD_W-1:0] reg_wdata,
  output logic [WORD_W-1:0] reg_rdata,
  input  logic [WORD_W-1:0] mw_data,
  output logic [NBYTES-1:0] mw_par,
  input  logic              mr_valid,
  input  logic [ADDR_W-1:0] mr_addr,
  input  logic [WORD_W-1:0] mr_data,
  input  logic [NBYTES-1:0] mr_par,
  output logic              bus_perr
);
  localparam int HI_LSB = WIN_LSB + FLD_W;

  logic              hit, sw_we, rd_fail;
  logic [NBYTES-1:0] wr_gen, rd_exp;
  logic [ADDR_W-1:0] cap;
  ctl_t              ctl;
  logic [FLD_W-1:0]  fld;
  logic [WORD_W-1:0] csr_word;

  pcsr_decode #(.BUS_AW(BUS_AW), .SEL_W(SEL_W), .BASE(CSR_BASE)) u_dec (
    .addr(reg_addr), .sel(cfg_sel), .hit(hit));

  pcsr_par_gen u_wgen (.d(mw_data), .p(wr_gen));
  pcsr_par_gen u_rgen (.d(mr_data), .p(rd_exp));

  assign mw_par  = wr_gen ^ {NBYTES{ctl.wwp}};
  assign rd_fail = mr_valid && (|(rd_exp ^ mr_par));
  assign sw_we   = reg_wr && hit;

  pcsr_regs #(.ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .init(bus_init), .sw_we(sw_we), .wdata(reg_wdata),
    .hw_err(rd_fail), .err_addr(mr_addr), .ctl(ctl), .cap(cap));

  always_comb begin
    fld = ctl.ext ? FLD_W'(cap[ADDR_W-1:HI_LSB]) : cap[HI_LSB-1:WIN_LSB];
    csr_word               = '0;
    csr_word[B_FLAG]       = ctl.flag;
    csr_word[B_EXT]        = ctl.ext;
    csr_word[B_FLD +: FLD_W] = fld;
    csr_word[B_WWP]        = ctl.wwp;
    csr_word[B_PEN]        = ctl.pen;
  end

  assign reg_rdata = (reg_rd && hit) ? csr_word : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        bus_perr <= 1'b0;
    else if (bus_init) bus_perr <= 1'b0;
    else               bus_perr <= rd_fail && ctl.pen;
  end

  a_r8_perr_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctl.pen) |=> !bus_perr);
  a_r8_perr_reported: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_fail && ctl.pen && !bus_init) |=> bus_perr);
  a_r2_wrong_parity_even: assert property (@(posedge clk) disable iff (!rst_n)
    ctl.wwp |-> ((($countones({mw_data[7:0], mw_par[0]}) & 1) == 0) &&
                 (($countones({mw_data[15:8], mw_par[1]}) & 1) == 0)));
  a_r10_perr_init: assert property (@(posedge clk) disable iff (!rst_n)
    bus_init |=> !bus_perr);
endmodule

// File: tb/pcsr_top_tb_top.sv
module pcsr_top_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_init = 1'b0;
  logic [3:0]  cfg_sel = 4'd5;
  logic [15:0] reg_addr = '0;
  logic        reg_wr = 1'b0;
  logic        reg_rd = 1'b0;
  logic [15:0] reg_wdata = '0;
  logic [15:0] reg_rdata;
  logic [15:0] mw_data = '0;
  logic [1:0]  mw_par;
  logic        mr_valid = 1'b0;
  logic [21:0] mr_addr = '0;
  logic [15:0] mr_data = '0;
  logic [1:0]  mr_par = '0;
  logic        bus_perr;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  localparam logic [15:0] CSRA  = 16'o172112;
  localparam logic [15:0] OTHER = 16'o172114;
  localparam logic [21:0] ADR_A = 22'h2ED246;
  localparam logic [21:0] ADR_B = 22'h155555;

  // {data, wrong-parity mode, expected {par1,par0}}
  localparam logic [18:0] VEC [8] = '{
    {16'h0000, 1'b0, 2'b11}, {16'h00FF, 1'b0, 2'b11},
    {16'h0100, 1'b0, 2'b01}, {16'h8007, 1'b0, 2'b00},
    {16'hFE7F, 1'b0, 2'b00}, {16'h0300, 1'b1, 2'b00},
    {16'h5501, 1'b1, 2'b01}, {16'h1234, 1'b1, 2'b01}};

  pcsr_top dut_i (.*);

  always #5 clk = ~clk;

  task automatic chk(string req, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic csr_wr(logic [15:0] a, logic [15:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic csr_rd(logic [15:0] a, output logic [15:0] d);
    reg_addr = a; reg_rd = 1'b1;
    #1 d = reg_rdata;
    reg_rd = 1'b0;
  endtask

  task automatic mem_rd(logic [21:0] a, logic [15:0] d, logic [1:0] p);
    @(negedge clk);
    mr_valid = 1'b1; mr_addr = a; mr_data = d; mr_par = p;
    @(negedge clk);
    mr_valid = 1'b0;
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual hung expected finish");
      summary();
    end
  end

  initial begin
    logic [15:0] rd;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    csr_rd(CSRA, rd); chk("R10 reset csr", rd, 16'h0000);
    chk("R10 reset perr", {15'b0, bus_perr}, 16'h0000);

    // R11 decode
    csr_wr(OTHER, 16'h0001);
    csr_rd(CSRA, rd); chk("R11 foreign write ignored", rd, 16'h0000);
    csr_wr(CSRA | 16'h1, 16'h0001);
    csr_rd(CSRA, rd); chk("R11 odd byte address hits", rd, 16'h0001);
    csr_rd(OTHER, rd); chk("R11 foreign read zero", rd, 16'h0000);
    reg_addr = CSRA; #1 chk("R11 no read enable", reg_rdata, 16'h0000);

    // R12 reserved bits
    csr_wr(CSRA, 16'hBFFF);
    csr_rd(CSRA, rd); chk("R12 reserved read zero", rd, 16'h8FE5);
    csr_wr(CSRA, 16'h0001);
    csr_rd(CSRA, rd); chk("R5 field protected while flagged", rd, 16'h0FE1);
    csr_wr(CSRA, 16'h0001);
    csr_rd(CSRA, rd); chk("R9 field writable when clear", rd, 16'h0001);

    // R1/R2 vector table
    for (int i = 0; i < 8; i++) begin
      csr_wr(CSRA, VEC[i][2] ? 16'h0004 : 16'h0000);
      mw_data = VEC[i][18:3];
      #1 chk(VEC[i][2] ? "R2 inverted parity" : "R1 odd parity", {14'b0, mw_par}, {14'b0, VEC[i][1:0]});
    end

    // R3/R4/R6/R8 capture
    csr_wr(CSRA, 16'h0001);
    mem_rd(ADR_A, 16'h1234, 2'b10);
    chk("R3 good read no perr", {15'b0, bus_perr}, 16'h0000);
    csr_rd(CSRA, rd); chk("R3 good read no flag", rd, 16'h0001);
    mem_rd(ADR_A, 16'h1234, 2'b11);
    chk("R8 perr reported", {15'b0, bus_perr}, 16'h0001);
    csr_rd(CSRA, rd); chk("R4 R6 capture low window", rd, 16'h8B41);
    @(negedge clk);
    chk("R8 perr single cycle", {15'b0, bus_perr}, 16'h0000);
    mem_rd(ADR_B, 16'h1234, 2'b00);
    chk("R3 high byte fail perr", {15'b0, bus_perr}, 16'h0001);
    csr_rd(CSRA, rd); chk("R5 first error held", rd, 16'h8B41);
    csr_wr(CSRA, 16'hC001);
    csr_rd(CSRA, rd); chk("R7 high window", rd, 16'hC161);
    csr_wr(CSRA, 16'h0001);
    csr_rd(CSRA, rd); chk("R5 clear keeps address", rd, 16'h0B41);
    csr_wr(CSRA, 16'h0000);
    csr_rd(CSRA, rd); chk("R9 field write", rd, 16'h0000);
    mem_rd(ADR_B, 16'h1234, 2'b00);
    chk("R8 no perr when disabled", {15'b0, bus_perr}, 16'h0000);
    csr_rd(CSRA, rd); chk("R8 capture without enable", rd, 16'h8540);
    csr_wr(CSRA, 16'h0000);

    // R9 same-cycle priority
    @(negedge clk);
    reg_addr = CSRA; reg_wdata = 16'h0004; reg_wr = 1'b1;
    mr_valid = 1'b1; mr_addr = ADR_A; mr_data = 16'h1234; mr_par = 2'b11;
    @(negedge clk);
    reg_wr = 1'b0; mr_valid = 1'b0;
    csr_rd(CSRA, rd); chk("R9 write beats capture", rd, 16'h0004);

    // R2 end to end
    mw_data = 16'h1234;
    #1 chk("R2 inverted word", {14'b0, mw_par}, 16'h0001);
    mem_rd(ADR_A, 16'h1234, mw_par);
    csr_rd(CSRA, rd); chk("R2 planted error caught", rd, 16'h8B44);

    // R10 bus init beats capture and perr
    csr_wr(CSRA, 16'h0001);
    @(negedge clk);
    bus_init = 1'b1; mr_valid = 1'b1; mr_addr = ADR_B; mr_par = 2'b00;
    @(negedge clk);
    bus_init = 1'b0; mr_valid = 1'b0;
    chk("R10 init clears perr", {15'b0, bus_perr}, 16'h0000);
    csr_rd(CSRA, rd); chk("R10 init clears csr", rd, 16'h0000);
    #1 chk("R10 init clears wrong-parity", {14'b0, mw_par}, 16'h0002);

    // R10 async reset
    mem_rd(ADR_B, 16'h1234, 2'b00);
    rst_n = 1'b0;
    #1 csr_rd(CSRA, rd); chk("R10 async reset", rd, 16'h0000);
    @(negedge clk);
    rst_n = 1'b1;

    done = 1;
    summary();
  end
endmodule